// File: doc/BRIEF.md
# Switch Reset and Polling Sequencer

This block holds the global control word and builds the global status word of a small Ethernet switch. Software reaches both through a 16-bit register port. A reset request in the control word sends a one-cycle reset pulse to every internal unit, such as the address table and the VLAN table. The block then collects one done pulse from each unit. Only when all of them have reported does it raise the init-ready status bit.

The same control word turns a PHY polling unit on and off. The polling state is a two-bit code in the status word. A freshly enabled unit spends a fixed settling period in an initialising state before it polls. Each entry into that state fires a PHY re-detection pulse. If the reset request and the polling enable are written together, the polling unit restarts from the beginning, whatever state it is in. A third control bit raises the frame length limit from 1518 to 1632 bytes.

Register traffic uses a valid/ready request channel and a valid/ready read-response channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A read response stays valid, with unchanged data, until `rsp_ready` accepts it. `req_ready` falls while an unaccepted response is held, so nothing is lost. Writes produce no response.

Top module: `sw_gctl_top`

## Requirements
- R1: During and right after the hardware reset, `unit_rst_o` is high and `init_ready_o` is low. In the first cycle after reset is released, `unit_rst_o` is low again. With the default boot setting, polling is enabled, so that same cycle shows the initialising state with `phy_redetect_o` high.
- R2: Writing 1 to control bit 15 (reset request) drives `unit_rst_o` high for exactly the one cycle after the write. Bit 15 then clears itself and reads back as 0.
- R3: The other control bits keep their written values through a software reset. Bit 10 drives `max_frame_long_o`: 1 selects the 1632-byte limit and 0 the 1518-byte limit.
- R4: `init_ready_o` (status bit 11) is low from the cycle after a reset request. It rises only after every bit of `unit_done_i` has pulsed since the reset pulse. Done pulses that arrive while `unit_rst_o` is high are ignored.
- R5: One cycle after control bit 14 (polling enable) reads 0, the polling state is disabled (code 00). One cycle after it is set while disabled, the state is initialising (code 01).
- R6: The initialising state lasts exactly INIT_CYCLES cycles and then moves to polling (code 10). Each entry into initialising pulses `phy_redetect_o` for one cycle.
- R7: A write with bits 15 and 14 both set restarts the polling unit from any state. The cycle after the reset pulse shows initialising with `phy_redetect_o` high, and the full settling period runs again.
- R8: The status word, read at address 0, has the polling state in bits 13:12, init-ready in bit 11 and zeros elsewhere. The control word is read at address 1. Other addresses read 0. Writes to status or to unmapped addresses change nothing.
- R9: A read response stays valid with stable data until `rsp_ready` is high. While it is held, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Register address (0 status, 1 control) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted when high |
| rsp_rdata | output | 16 | Read data |
| unit_done_i | input | NUM_UNITS | Per-unit initialisation done pulses |
| unit_rst_o | output | 1 | Reset pulse to the internal units |
| init_ready_o | output | 1 | All units initialised |
| poll_state_o | output | 2 | Polling state code (00 off, 01 init, 10 polling) |
| phy_redetect_o | output | 1 | Pulse starting a PHY detection pass |
| max_frame_long_o | output | 1 | 1632-byte frame limit selected |

## Verification
The assertions assume that the units raise their done pulses only after they have seen the reset pulse. They also assume that a requester holds its request fields steady while `req_valid` waits for `req_ready`. The bench drives every input on the falling clock edge and keeps request fields fixed until acceptance. It pulses done lines once the reset pulse is over, except in one deliberate case that checks that early pulses are ignored. Response back-pressure is applied only by holding `rsp_ready` low, which the handshake rules allow.

// File: rtl/sw_gctl_pkg.sv
package sw_gctl_pkg;
  localparam int REG_W = 16;

  localparam int CTL_RST_BIT      = 15;
  localparam int CTL_POLL_EN_BIT  = 14;
  localparam int CTL_LONG_FRM_BIT = 10;

  localparam int STS_READY_BIT    = 11;
  localparam int STS_STATE_LSB    = 12;

  typedef enum logic [1:0] {
    POLL_OFF  = 2'b00,
    POLL_INIT = 2'b01,
    POLL_RUN  = 2'b10
  } poll_state_e;
endpackage

// File: rtl/gctl_regfile.sv
module gctl_regfile
  import sw_gctl_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int STATUS_ADDR  = 0,
  parameter int CONTROL_ADDR = 1,
  parameter bit POLL_AT_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [REG_W-1:0]  rsp_rdata,
  input  logic [REG_W-1:0]  status_word,
  output logic              rst_req_o,
  output logic              poll_en_o,
  output logic              long_frame_o
);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CONTROL_ADDR);
  localparam logic [REG_W-1:0]  CTL_RESET =
    (REG_W'(1) << CTL_RST_BIT) | (POLL_AT_BOOT ? (REG_W'(1) << CTL_POLL_EN_BIT) : '0);

  logic [REG_W-1:0] ctl_q, ctl_d;
  logic [REG_W-1:0] rdata_mux;
  logic             accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  // a reset request arriving while a pulse is out merges with that pulse
  always_comb begin
    ctl_d = ctl_q;
    ctl_d[CTL_RST_BIT] = 1'b0;
    if (accept && req_write && req_addr == CTL_A) begin
      ctl_d = req_wdata;
      ctl_d[CTL_RST_BIT] = req_wdata[CTL_RST_BIT] & ~ctl_q[CTL_RST_BIT];
    end
  end

  always_comb begin
    if (req_addr == CTL_A)      rdata_mux = ctl_q;
    else if (req_addr == STS_A) rdata_mux = status_word;
    else                        rdata_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rst_req_o    = ctl_q[CTL_RST_BIT];
  assign poll_en_o    = ctl_q[CTL_POLL_EN_BIT];
  assign long_frame_o = ctl_q[CTL_LONG_FRM_BIT];

  // R2: request bit never stays set two cycles in a row
  a_r2_rst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  // R9: held response keeps valid and data
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R3: long-frame select moves only on an accepted control write
  a_r3_frame_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(long_frame_o));
endmodule

// File: rtl/gctl_ready_tracker.sv
module gctl_ready_tracker #(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic [NUM_UNITS-1:0] done_i,
  output logic                 ready_o
);
  logic [NUM_UNITS-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (clear_i) seen_q <= '0;
    else              seen_q <= seen_q | done_i;
  end

  assign ready_o = (&seen_q) & ~clear_i;

  // R4: collected done flags only accumulate between reset pulses
  a_r4_seen_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((seen_q & $past(seen_q)) == $past(seen_q)));

  // R4: readiness is withdrawn after every reset pulse
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !ready_o);
endmodule

// File: rtl/gctl_poll_fsm.sv
module gctl_poll_fsm
  import sw_gctl_pkg::*;
#(
  parameter int INIT_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable_i,
  input  logic        restart_i,
  output poll_state_e state_o,
  output logic        redetect_o
);
  localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

  poll_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             go_init;

  always_comb begin
    state_d = state_q;
    go_init = 1'b0;
    if (restart_i && enable_i) begin
      go_init = 1'b1;
    end else if (!enable_i) begin
      state_d = POLL_OFF;
    end else begin
      case (state_q)
        POLL_OFF:  go_init = 1'b1;
        POLL_INIT: if (cnt_q == LAST) state_d = POLL_RUN;
        POLL_RUN:  state_d = POLL_RUN;
        default:   state_d = POLL_OFF;
      endcase
    end
    if (go_init) state_d = POLL_INIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= POLL_OFF;
      cnt_q      <= '0;
      redetect_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      redetect_o <= go_init;
      if (go_init)                 cnt_q <= '0;
      else if (state_q == POLL_INIT) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign state_o = state_q;

  // R5: disabled enable forces the off code next cycle
  a_r5_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (state_o == POLL_OFF));

  // R6: polling is never reached straight from off
  a_r6_no_skip_init: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == POLL_OFF) |=> (state_o != POLL_RUN));

  // R6: re-detection pulse only accompanies the initialising state
  a_r6_redetect_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    redetect_o |-> (state_o == POLL_INIT));

  // R7: combined reset and enable restarts the unit
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && enable_i) |=> (state_o == POLL_INIT && redetect_o));
endmodule

// File: rtl/sw_gctl_top.sv
module sw_gctl_top
  import sw_gctl_pkg::*;
#(
  parameter int NUM_UNITS    = 4,
  parameter int INIT_CYCLES  = 8,
  parameter int ADDR_W       = 2,
  parameter int STATUS_ADDR  = 0,
  parameter int CONTROL_ADDR = 1,
  parameter bit POLL_AT_BOOT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [15:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [15:0]          rsp_rdata,
  input  logic [NUM_UNITS-1:0] unit_done_i,
  output logic                 unit_rst_o,
  output logic                 init_ready_o,
  output logic [1:0]           poll_state_o,
  output logic                 phy_redetect_o,
  output logic                 max_frame_long_o
);
  logic             rst_req, poll_en, ready;
  poll_state_e      pstate;
  logic [REG_W-1:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[STS_READY_BIT] = ready;
    status_word[STS_STATE_LSB +: 2] = pstate;
  end

  gctl_regfile #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .CONTROL_ADDR(CONTROL_ADDR), .POLL_AT_BOOT(POLL_AT_BOOT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .status_word(status_word),
    .rst_req_o(rst_req), .poll_en_o(poll_en), .long_frame_o(max_frame_long_o)
  );

  gctl_ready_tracker #(.NUM_UNITS(NUM_UNITS)) ready_i (
    .clk(clk), .rst_n(rst_n), .clear_i(rst_req),
    .done_i(unit_done_i), .ready_o(ready)
  );

  gctl_poll_fsm #(.INIT_CYCLES(INIT_CYCLES)) poll_i (
    .clk(clk), .rst_n(rst_n), .enable_i(poll_en), .restart_i(rst_req),
    .state_o(pstate), .redetect_o(phy_redetect_o)
  );

  assign unit_rst_o   = rst_req;
  assign init_ready_o = ready;
  assign poll_state_o = pstate;

  // R2: the unit reset pulse is one cycle wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst_o |=> !unit_rst_o);

  // R4: ready is low right after the pulse
  a_r4_not_ready_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst_o |=> !init_ready_o);
endmodule

// File: tb/sw_gctl_top_tb_top.sv
`timescale 1ns/1ps
module sw_gctl_top_tb_top;
  localparam int NU = 4;
  localparam int IC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [NU-1:0] unit_done = '0;
  logic req_ready, rsp_valid, unit_rst, init_ready, redetect, long_frm;
  logic [15:0] rsp_rdata;
  logic [1:0] pstate;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sw_gctl_top #(.NUM_UNITS(NU), .INIT_CYCLES(IC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .unit_done_i(unit_done), .unit_rst_o(unit_rst), .init_ready_o(init_ready),
    .poll_state_o(pstate), .phy_redetect_o(redetect), .max_frame_long_o(long_frm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic done_pulse(input logic [NU-1:0] m);
    @(negedge clk); unit_done = m;
    @(negedge clk); unit_done = '0;
    settle();
  endtask

  // scoreboard monitor: one response per handshake
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
        end else begin
          chk(tag_q.pop_front(), 32'(rsp_rdata), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    settle();
    chk("R1 unit_rst in reset", 32'(unit_rst), 1);
    chk("R1 ready in reset", 32'(init_ready), 0);
    chk("R1 state in reset", 32'(pstate), 0);
    chk("R9 rsp idle in reset", 32'(rsp_valid), 0);

    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); settle();
    chk("R1 pulse ends", 32'(unit_rst), 0);
    chk("R1 boot init state", 32'(pstate), 1);
    chk("R6 boot redetect", 32'(redetect), 1);
    repeat (IC - 1) @(negedge clk);
    settle();
    chk("R6 still init", 32'(pstate), 1);
    @(negedge clk); settle();
    chk("R6 polling after period", 32'(pstate), 2);

    // R4: ready only after all units report
    for (int i = 0; i < NU; i++) begin
      done_pulse(NU'(1) << i);
      chk("R4 ready progression", 32'(init_ready), (i == NU - 1) ? 1 : 0);
    end
    rd(2'd0, 16'h2800, "R8 status polling+ready");

    // R3: long-frame select
    wr(2'd1, 16'h4400);
    settle();
    chk("R3 long frame on", 32'(long_frm), 1);
    chk("R5 enable kept, no restart", 32'(redetect), 0);
    rd(2'd1, 16'h4400, "R3 control readback");

    // R5: disable
    wr(2'd1, 16'h0400);
    settle();
    chk("R5 state one cycle later not yet", 32'(pstate), 2);
    @(negedge clk); settle();
    chk("R5 disabled code", 32'(pstate), 0);
    rd(2'd0, 16'h0800, "R8 status off+ready");

    // R5/R6: re-enable
    wr(2'd1, 16'h4400);
    settle();
    chk("R5 off before enable seen", 32'(pstate), 0);
    @(negedge clk); settle();
    chk("R5 init after enable", 32'(pstate), 1);
    chk("R6 redetect on entry", 32'(redetect), 1);
    @(negedge clk); settle();
    chk("R6 redetect one cycle", 32'(redetect), 0);

    // R7: restart mid-init, done pulses during reset pulse ignored (R4)
    wr(2'd1, 16'hC400);
    settle();
    chk("R2 reset pulse", 32'(unit_rst), 1);
    chk("R4 ready dropped", 32'(init_ready), 0);
    unit_done = '1;
    @(negedge clk); unit_done = '0; settle();
    chk("R2 pulse one cycle", 32'(unit_rst), 0);
    chk("R7 restart init", 32'(pstate), 1);
    chk("R7 restart redetect", 32'(redetect), 1);
    chk("R4 early dones ignored", 32'(init_ready), 0);
    repeat (IC - 1) @(negedge clk);
    settle();
    chk("R7 full period rerun", 32'(pstate), 1);
    @(negedge clk); settle();
    chk("R6 polling after restart", 32'(pstate), 2);
    rd(2'd1, 16'h4400, "R2 bit self-cleared, R3 kept");
    chk("R3 long frame kept", 32'(long_frm), 1);
    done_pulse(4'b0011);
    chk("R4 partial", 32'(init_ready), 0);
    done_pulse(4'b1100);
    chk("R4 all reported", 32'(init_ready), 1);

    // reset without enable
    wr(2'd1, 16'h8400);
    settle();
    chk("R2 pulse again", 32'(unit_rst), 1);
    @(negedge clk); settle();
    chk("R5 off after reset w/o enable", 32'(pstate), 0);
    chk("R3 long frame through reset", 32'(long_frm), 1);
    done_pulse('1);
    chk("R4 ready again", 32'(init_ready), 1);

    // R8: ignored writes, unmapped reads
    wr(2'd0, 16'hFFFF);
    wr(2'd3, 16'h1234);
    rd(2'd0, 16'h0800, "R8 status write ignored");
    rd(2'd1, 16'h0400, "R8 control unchanged");
    rd(2'd3, 16'h0000, "R8 unmapped reads zero");

    // R9: back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd(2'd0, 16'h0800, "R9 held response");
    settle();
    chk("R9 rsp valid held", 32'(rsp_valid), 1);
    chk("R9 req blocked", 32'(req_ready), 0);
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    settle();
    chk("R9 still valid", 32'(rsp_valid), 1);
    chk("R9 data stable", 32'(rsp_rdata), 32'(held));
    @(negedge clk); rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    settle();
    chk("R9 response drained", 32'(rsp_valid), 0);
    chk("R9 scoreboard empty", 32'(exp_q.size()), 0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule